// File: doc/BRIEF.md
# Modem Status Delta Tracker

This block holds the 8-bit modem status register of a 16550-style serial port. The upper nibble carries the present levels of the four modem input lines: clear-to-send, data-set-ready, ring indicator and carrier detect. The lower nibble carries sticky change flags, one per line. On each update the block compares a new 4-bit sample with the stored levels and raises the change flag of every line that moved. It then stores the new levels.

The ring-indicator flag is a trailing-edge flag. It rises only when the ring line goes from 1 to 0. The other three flags rise on any change. Flags accumulate across updates until the host reads the register and pulses the read-clear strobe. An interrupt request is raised while any flag is set, provided the modem-status interrupt enable is 1.

The block also keeps the 5-bit modem-control value. Writing that value always triggers an update. When the loopback bit of the value is set, the sample is taken from the control outputs and not from the pins. Pin synchronisation is done outside the block.

Top module: `modem_status_tracker`

## Requirements
- R1: After reset `msrValue` is 0x00, the stored control value is 0 and `irq` is 0.
- R2: On an update, a change of CTS (sample bit 0), DSR (sample bit 1) or DCD (sample bit 3) relative to the stored level sets the flag in `msrValue` bit 0, bit 1 or bit 3 respectively.
- R3: `msrValue` bit 2 (trailing ring edge) is set by an update only when the stored RI (bit 6) is 1 and the new RI (sample bit 2) is 0. A rising RI does not set it.
- R4: On an update the levels are replaced by the new sample: CTS goes to bit 4, DSR to bit 5, RI to bit 6 and DCD to bit 7.
- R5: Flags that are already set stay set through later updates. An update only adds flags.
- R6: A `readClear` pulse clears bits 3:0 and leaves bits 7:4 unchanged. Flags raised by an update in the same cycle survive the clear.
- R7: With no `sampleStrobe`, `ctrlWrite` or `readClear`, `msrValue` does not change, whatever `lineSample` does.
- R8: A `ctrlWrite` with `ctrlValue` bit 4 (loopback) set updates the register from the control bits. CTS comes from RTS (bit 1), DSR from DTR (bit 0), RI from OUT1 (bit 2) and DCD from OUT2 (bit 3). A `ctrlWrite` with bit 4 clear updates the register from `lineSample`.
- R9: While loopback is active, `sampleStrobe` is ignored.
- R10: `irq` is 1 exactly when any of bits 3:0 is set and `irqEnable` is 1.
- R11: Results appear in `msrValue` on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| lineSample | input | 4 | Synchronised line levels {DCD, RI, DSR, CTS} |
| sampleStrobe | input | 1 | Update from `lineSample` |
| ctrlWrite | input | 1 | Write of the modem-control value; always triggers an update |
| ctrlValue | input | 5 | {LOOP, OUT2, OUT1, RTS, DTR} |
| readClear | input | 1 | Host read-clear of the change flags |
| irqEnable | input | 1 | Modem-status interrupt enable |
| msrValue | output | 8 | Register value: flags in 3:0, levels in 7:4 |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a rising RI and checks that no flag appears, since a design using any-change detection for RI would flag it. It then drives a falling RI and checks for the flag. It repeats an unchanged sample after a flagged one, which catches a design that rebuilds the flags each update instead of accumulating them. It coincides a clear with a falling RI, which catches a clear that has priority over a new edge. In loopback it swaps the RTS and DTR lines to catch a crossed mapping. It pulses the pin strobe to catch a design that lets pins leak through, and changes the sample without a strobe to catch an unqualified update.

// File: rtl/modem_status_pkg.sv
package modem_status_pkg;
  localparam int LINES     = 4;
  localparam int REG_W     = 2 * LINES;
  localparam int CTRL_W    = 5;
  localparam int RI_LINE   = 2;
  localparam int LOOP_BIT  = 4;

  typedef struct packed {
    logic             doUpdate;
    logic             clearFlags;
    logic [LINES-1:0] sample;
  } statusCmd_t;
endpackage

// File: rtl/status_ctrl.sv
module status_ctrl
  import modem_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineSample,
  input  logic              sampleStrobe,
  input  logic              ctrlWrite,
  input  logic [CTRL_W-1:0] ctrlValue,
  input  logic              readClear,
  output statusCmd_t        cmd,
  output logic              loopMode
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [LINES-1:0]  loopSample;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctrlWrite) ctrlReg <= ctrlValue;
  end

  assign loopMode = ctrlReg[LOOP_BIT];

  // loopback wiring from the newly written control value
  assign loopSample[0] = ctrlValue[1]; // CTS <- RTS
  assign loopSample[1] = ctrlValue[0]; // DSR <- DTR
  assign loopSample[2] = ctrlValue[2]; // RI  <- OUT1
  assign loopSample[3] = ctrlValue[3]; // DCD <- OUT2

  always_comb begin
    cmd.clearFlags = readClear;
    cmd.doUpdate   = 1'b0;
    cmd.sample     = lineSample;
    if (ctrlWrite) begin
      cmd.doUpdate = 1'b1;
      cmd.sample   = ctrlValue[LOOP_BIT] ? loopSample : lineSample;
    end else if (sampleStrobe && !loopMode) begin
      cmd.doUpdate = 1'b1;
    end
  end
endmodule

// File: rtl/status_datapath.sv
module status_datapath
  import modem_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  statusCmd_t       cmd,
  output logic [REG_W-1:0] regValue
);
  logic [LINES-1:0] levels;
  logic [LINES-1:0] flags;
  logic [LINES-1:0] newFlags;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == RI_LINE) begin : g_trail
      assign newFlags[i] = cmd.doUpdate & levels[i] & ~cmd.sample[i];
    end else begin : g_any
      assign newFlags[i] = cmd.doUpdate & (levels[i] ^ cmd.sample[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levels <= '0;
      flags  <= '0;
    end else begin
      flags <= (cmd.clearFlags ? '0 : flags) | newFlags;
      if (cmd.doUpdate) levels <= cmd.sample;
    end
  end

  assign regValue = {levels, flags};
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import modem_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineSample,
  input  logic              sampleStrobe,
  input  logic              ctrlWrite,
  input  logic [CTRL_W-1:0] ctrlValue,
  input  logic              readClear,
  input  logic              irqEnable,
  output logic [REG_W-1:0]  msrValue,
  output logic              irq
);
  statusCmd_t cmd;
  logic       loopMode;

  status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lineSample(lineSample),
    .sampleStrobe(sampleStrobe), .ctrlWrite(ctrlWrite),
    .ctrlValue(ctrlValue), .readClear(readClear),
    .cmd(cmd), .loopMode(loopMode)
  );

  status_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .regValue(msrValue)
  );

  assign irq = irqEnable & (|msrValue[LINES-1:0]);
endmodule

// File: rtl/modem_status_checker.sv
module modem_status_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] lineSample,
  input logic       sampleStrobe,
  input logic       ctrlWrite,
  input logic       readClear,
  input logic       irqEnable,
  input logic       loopMode,
  input logic [7:0] msrValue,
  input logic       irq
);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(readClear)) |->
      ((msrValue[3:0] & $past(msrValue[3:0])) == $past(msrValue[3:0])));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(sampleStrobe) && !$past(ctrlWrite) && !$past(readClear))
      |-> $stable(msrValue));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(readClear) && !$past(sampleStrobe) && !$past(ctrlWrite))
      |-> (msrValue[3:0] == 4'h0 && msrValue[7:4] == $past(msrValue[7:4])));

  a_r3_no_rise_flag: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(readClear) && $past(sampleStrobe) && !$past(ctrlWrite)
      && !$past(loopMode) && !$past(msrValue[6])) |-> !msrValue[2]);

  a_r9_loop_ignore: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(loopMode) && !$past(ctrlWrite) && !$past(readClear))
      |-> $stable(msrValue));

  a_r10_irq: assert property (@(posedge clk) disable iff (!rstN)
    irq == (irqEnable && (msrValue[3:0] != 4'h0)));
endmodule

bind modem_status_tracker modem_status_checker u_chk (
  .clk(clk), .rstN(rstN), .lineSample(lineSample),
  .sampleStrobe(sampleStrobe), .ctrlWrite(ctrlWrite),
  .readClear(readClear), .irqEnable(irqEnable),
  .loopMode(loopMode), .msrValue(msrValue), .irq(irq)
);

// File: tb/modem_status_tracker_test.sv
module modem_status_tracker_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] lineSample = '0;
  logic       sampleStrobe = 1'b0;
  logic       ctrlWrite = 1'b0;
  logic [4:0] ctrlValue = '0;
  logic       readClear = 1'b0;
  logic       irqEnable = 1'b0;
  logic [7:0] msrValue;
  logic       irq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  modem_status_tracker uut (
    .clk(clk), .rstN(rstN), .lineSample(lineSample),
    .sampleStrobe(sampleStrobe), .ctrlWrite(ctrlWrite),
    .ctrlValue(ctrlValue), .readClear(readClear),
    .irqEnable(irqEnable), .msrValue(msrValue), .irq(irq)
  );

  // {strobe, readClear, sample[3:0], expected[7:0]}
  localparam int NVEC = 11;
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 4'b0001, 8'h11},  // R2 R4 CTS rises
    {1'b1, 1'b0, 4'b0001, 8'h11},  // R5 no change, flag kept
    {1'b1, 1'b0, 4'b0101, 8'h51},  // R3 RI rise, no flag
    {1'b1, 1'b0, 4'b0001, 8'h15},  // R3 RI falls
    {1'b0, 1'b1, 4'b0001, 8'h10},  // R6 clear
    {1'b1, 1'b0, 4'b1011, 8'hBA},  // R2 DSR, DCD
    {1'b1, 1'b0, 4'b0000, 8'h0B},  // R5 R2 accumulate
    {1'b1, 1'b1, 4'b0100, 8'h40},  // R6 R3 clear with rise
    {1'b1, 1'b1, 4'b0000, 8'h04},  // R6 new edge survives clear
    {1'b0, 1'b1, 4'b0000, 8'h00},  // R6 clear
    {1'b0, 1'b0, 4'b1111, 8'h00}   // R7 no strobe
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // apply inputs for one edge, then check after it
  task automatic cycle(input logic sStb, input logic rClr, input logic cWr,
                       input logic [4:0] cVal, input logic [3:0] smp);
    @(negedge clk);
    sampleStrobe = sStb; readClear = rClr; ctrlWrite = cWr;
    ctrlValue = cVal; lineSample = smp;
    @(negedge clk);
    sampleStrobe = 1'b0; readClear = 1'b0; ctrlWrite = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", msrValue, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][13], VEC[i][12], 1'b0, 5'h00, VEC[i][11:8]);
      check($sformatf("R11 vector %0d", i), msrValue, VEC[i][7:0]);
    end

    irqEnable = 1'b1;
    @(negedge clk);
    check("R10 irq no flags", {7'b0, irq}, 8'h00);

    cycle(1'b0, 1'b0, 1'b1, 5'h12, 4'b0000);
    check("R8 loop RTS->CTS", msrValue, 8'h11);
    check("R10 irq on", {7'b0, irq}, 8'h01);
    irqEnable = 1'b0;
    @(negedge clk);
    check("R10 irq disabled", {7'b0, irq}, 8'h00);

    cycle(1'b1, 1'b0, 1'b0, 5'h12, 4'b1111);
    check("R9 strobe ignored in loopback", msrValue, 8'h11);

    cycle(1'b0, 1'b0, 1'b1, 5'h1D, 4'b1111);
    check("R8 loop DTR OUT1 OUT2", msrValue, 8'hEB);

    cycle(1'b0, 1'b0, 1'b1, 5'h00, 4'b0000);
    check("R8 leave loop uses pins", msrValue, 8'h0F);

    cycle(1'b1, 1'b0, 1'b0, 5'h00, 4'b0010);
    check("R9 strobe active after loop", msrValue, 8'h2F);

    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", msrValue, 8'h00);
    rstN = 1'b1;
    cycle(1'b0, 1'b0, 1'b0, 5'h00, 4'b0000);
    check("R1 control cleared, no loop", msrValue, 8'h00);
    cycle(1'b1, 1'b0, 1'b0, 5'h00, 4'b0001);
    check("R1 pins used after reset", msrValue, 8'h11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule